// File: doc/BRIEF.md
# Configuration Bitstream Streaming Host

This block sits on the host side of a configuration link and pushes a bitstream into a target device, one word per interface clock period, over a parallel bus with a valid strobe. Words come from a local source through a valid/ready handshake. The source offers a word by raising `src_valid`. The host takes it in the single host cycle where both `src_valid` and `src_ready` are high. When the target is not ready, when configuration is done, or between launch slots, the host holds `src_ready` low, and the source must keep its word stable until it is taken. Across the link the pacing runs the other way. The target drives an asynchronous ready line, and the host passes it through a two-flop synchronizer. A word is launched only while the synchronized ready is high. The target captures a word on each rising edge of `cfg_clk` that finds `cfg_valid` high.

The host makes `cfg_clk` from its own clock at half the host rate. `cfg_clk` runs without a break from the accepted `start` until the end of configuration, including periods with no data. Data and valid change only on the host edge where `cfg_clk` falls, so they are stable at every rising edge. The configuration-done input is also synchronized. Once it is seen, the host sends no more data and gives a programmable number of trailing clock periods with valid low. It then stops `cfg_clk` in the low state and drops `busy`. A programmable timer watches for a source that stays empty too long and sets a sticky error flag.

The data width `DATA_W` may be 8, 16 or 32. `CNT_W` sets the width of the timeout and tail-length inputs.

Top module: `cfg_stream_host`

## Requirements
- R1: While reset is asserted, `busy`, `cfg_clk`, `cfg_valid`, `src_ready` and `err` are all low.
- R2: From the host edge that accepts `start` until the clock is gated off, `cfg_clk` changes level on every host clock edge. This holds whether or not data is moving.
- R3: Source words reach `cfg_data` in the order they were taken, each exactly once. A word is carried by the first rising edge of `cfg_clk` after it is taken, with `cfg_valid` high. `cfg_valid` rises only on a launch where the synchronized ready was high.
- R4: After `tgt_ready` falls, `cfg_valid` is low at every rising edge of `cfg_clk` from the fifth host cycle on. This is two flops of synchronizer followed by at most two host cycles to reach the next launch slot.
- R5: While `tgt_ready` stays low, no word is taken from the source and `cfg_valid` stays low. `cfg_clk` keeps running.
- R6: When the source is empty and the target is ready, `cfg_valid` stays low and `cfg_clk` keeps running. With `timeout_lim` = 0 the timeout is disabled and `err` never rises.
- R7: With `timeout_lim` = L > 0 and the source empty from the start, `err` rises at the host edge 2·L cycles after the edge that accepts `start`. The timer counts consecutive launch slots with `src_valid` low. `err` stays high until the next accepted `start` clears it.
- R8: Suppose `cfg_done` is raised just after a host edge that left `cfg_clk` high. Then exactly `tail_len`+2 rising edges of `cfg_clk` follow before `busy` falls. Every one of them after the first has `cfg_valid` low.
- R9: Once gated off, the host holds `cfg_clk`, `cfg_valid`, `src_ready` and `busy` low until the next `start`.
- R10: A `start` pulse while `busy` is high has no effect: `err` keeps its value and the word stream goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a configuration run when idle |
| timeout_lim | input | CNT_W | Empty-source limit in interface clock periods; 0 disables it |
| tail_len | input | CNT_W | Trailing clock periods after done, minus one |
| src_data | input | DATA_W | Word offered by the source |
| src_valid | input | 1 | Source has a word |
| src_ready | output | 1 | Host takes the word in this cycle |
| tgt_ready | input | 1 | Target can accept data (asynchronous) |
| cfg_done | input | 1 | Target reports configuration complete (asynchronous) |
| cfg_clk | output | 1 | Interface clock, half the host rate |
| cfg_data | output | DATA_W | Interface data bus |
| cfg_valid | output | 1 | Interface word strobe |
| busy | output | 1 | High from accepted start until the clock is gated |
| err | output | 1 | Sticky source-starvation flag |

## Verification
The bench toggles the target ready line in stretches long enough to show the synchronizer window. A design that trusted the raw line, or ignored it, would either lose words or keep strobing after the window. It also raises done on a fixed clock phase and counts the trailing edges for several tail lengths. An off-by-one in the tail counter or a clock that stops early shows up as a wrong edge count. The timeout is swept over small limits and checked to the exact cycle, and a start pulse in mid-run confirms that the flag is not cleared while busy.

// File: rtl/cfg_stream_pkg.sv
`timescale 1ns/1ps
package cfg_stream_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_TAIL   = 2'd2
  } host_state_e;
endpackage

// File: rtl/cfg_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer, one independent chain per bit.
module cfg_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/cfg_clk_pacer.sv
`timescale 1ns/1ps
// Interface clock at half the host rate. The launch slot is the host edge
// where the interface clock falls.
module cfg_clk_pacer (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cfg_clk,
  output logic launch
);
  logic phase_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= 1'b0;
    else if (run) phase_q <= ~phase_q;
    else          phase_q <= 1'b0;
  end
  assign cfg_clk = phase_q;
  assign launch  = run & phase_q;
endmodule

// File: rtl/cfg_cycle_timer.sv
`timescale 1ns/1ps
// Saturating tick counter with synchronous clear (clear wins).
module cfg_cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (tick && count != TOP) count <= count + W'(1);
  end
endmodule

// File: rtl/cfg_stream_host.sv
`timescale 1ns/1ps
module cfg_stream_host
  import cfg_stream_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  timeout_lim,
  input  logic [CNT_W-1:0]  tail_len,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic              tgt_ready,
  input  logic              cfg_done,
  output logic              cfg_clk,
  output logic [DATA_W-1:0] cfg_data,
  output logic              cfg_valid,
  output logic              busy,
  output logic              err
);
  localparam int NSYNC = 2;

  host_state_e       state_q;
  logic [NSYNC-1:0]  sync_q;
  logic              rdy_sync, done_sync, launch;
  logic              in_stream, in_tail, pop;
  logic              to_clr, to_tick, to_hit, tail_hit;
  logic [CNT_W-1:0]  idle_cnt, tail_cnt;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, err_q;

  cfg_sync2 #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cfg_done, tgt_ready}),
    .q     (sync_q)
  );
  assign rdy_sync  = sync_q[0];
  assign done_sync = sync_q[1];

  assign busy      = (state_q != ST_IDLE);
  assign in_stream = (state_q == ST_STREAM);
  assign in_tail   = (state_q == ST_TAIL);

  cfg_clk_pacer u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .cfg_clk (cfg_clk),
    .launch  (launch)
  );

  // Take a word only in a launch slot with the target ready and not done.
  assign src_ready = in_stream & launch & rdy_sync & ~done_sync;
  assign pop       = src_ready & src_valid;

  // Starvation timer: consecutive launch slots with an empty source.
  assign to_clr  = ~in_stream | (launch & src_valid);
  assign to_tick = in_stream & launch & ~src_valid & ~done_sync;
  assign to_hit  = to_tick & (timeout_lim != '0) &
                   (idle_cnt == timeout_lim - CNT_W'(1));

  cfg_cycle_timer #(.W(CNT_W)) u_idle_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (to_clr),
    .tick  (to_tick),
    .count (idle_cnt)
  );

  // Trailing clock periods after done.
  cfg_cycle_timer #(.W(CNT_W)) u_tail_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~in_tail),
    .tick  (in_tail & launch),
    .count (tail_cnt)
  );
  assign tail_hit = (tail_cnt == tail_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          valid_q <= 1'b0;
          if (start) begin
            state_q <= ST_STREAM;
            err_q   <= 1'b0;
          end
        end
        ST_STREAM: begin
          if (launch) begin
            if (done_sync) begin
              state_q <= ST_TAIL;
              valid_q <= 1'b0;
            end else begin
              valid_q <= pop;
              if (pop) data_q <= src_data;
            end
          end
          if (to_hit) err_q <= 1'b1;
        end
        ST_TAIL: begin
          valid_q <= 1'b0;
          if (launch && tail_hit) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_data  = data_q;
  assign cfg_valid = valid_q;
  assign err       = err_q;
endmodule

// File: rtl/cfg_stream_host_chk.sv
`timescale 1ns/1ps
module cfg_stream_host_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic err,
  input logic cfg_clk,
  input logic cfg_valid,
  input logic src_ready,
  input logic rdy_sync,
  input logic done_sync
);
  assert_clk_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cfg_clk != $past(cfg_clk)));

  assert_valid_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(rdy_sync));

  assert_valid_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_sync && !$past(rdy_sync) && !$past(rdy_sync, 2)) |-> !cfg_valid);

  assert_err_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> ($past(start) && !$past(busy)));

  assert_tail_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_sync && $past(done_sync) && $past(done_sync, 2)) |-> !cfg_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cfg_clk && !cfg_valid && !src_ready));
endmodule

bind cfg_stream_host cfg_stream_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .err       (err),
  .cfg_clk   (cfg_clk),
  .cfg_valid (cfg_valid),
  .src_ready (src_ready),
  .rdy_sync  (rdy_sync),
  .done_sync (done_sync)
);

// File: tb/sim_cfg_stream_host.sv
`timescale 1ns/1ps
module sim_cfg_stream_host;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] tlim = '0;
  logic [CW-1:0] tlen = '0;
  logic [DW-1:0] src_data = '0;
  logic          src_valid = 1'b0;
  logic          tgt_ready = 1'b0;
  logic          cfg_done = 1'b0;
  logic          src_ready, cfg_clk, cfg_valid, busy, err;
  logic [DW-1:0] cfg_data;

  int n_chk = 0, n_fail = 0;
  int tx_idx = 0, src_total = 0, rx_idx = 0, cyc = 0;
  int viol = 0, lowcnt = 0, r2_bad = 0;
  bit hs = 1'b0, gap_en = 1'b0, finished = 1'b0;
  bit pc = 1'b0, pb = 1'b0;

  cfg_stream_host #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .timeout_lim(tlim), .tail_len(tlen),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .tgt_ready(tgt_ready), .cfg_done(cfg_done), .cfg_clk(cfg_clk),
    .cfg_data(cfg_data), .cfg_valid(cfg_valid), .busy(busy), .err(err)
  );

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] word(input int i);
    return DW'(i * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Source model: advances after each handshake seen before the edge.
  initial forever begin
    @(posedge clk);
    if (hs) tx_idx++;
    cyc++;
    #1;
    src_valid = (tx_idx < src_total) && !(gap_en && (cyc % 3 == 0));
    src_data  = word(tx_idx);
  end

  // Target model and clock monitor, sampled mid-cycle.
  initial forever begin
    @(negedge clk);
    hs = src_valid && src_ready;
    if (!rst_n) begin
      pc = 1'b0; pb = 1'b0; lowcnt = 0;
    end else begin
      lowcnt = tgt_ready ? 0 : lowcnt + 1;
      if (cfg_clk && !pc && cfg_valid) begin
        chk(cfg_data == word(rx_idx), "R3 word order", cfg_data, word(rx_idx));
        rx_idx++;
        if (lowcnt >= 5) viol++;
      end
      if (busy && pb && cfg_clk == pc) r2_bad++;
      pc = cfg_clk;
      pb = busy;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    for (int g = 0; g < 4000 && rx_idx < target; g++) @(posedge clk);
  endtask

  // R8/R9: raise done with cfg_clk high, count trailing rises, then idle.
  task automatic do_tail(input int n);
    int rises, vbad, g, quiet;
    bit p;
    tlen = CW'(n);
    do begin @(posedge clk); #1; end while (!cfg_clk);
    cfg_done = 1'b1;
    p = 1'b1; rises = 0; vbad = 0; g = 0;
    while (busy && g < 2000) begin
      @(negedge clk);
      if (cfg_clk && !p) begin
        rises++;
        if (rises >= 2 && cfg_valid) vbad++;
      end
      p = cfg_clk;
      g++;
    end
    chk(rises == n + 2, "R8 trailing rises", rises, n + 2);
    chk(vbad == 0, "R8 valid low in tail", vbad, 0);
    @(posedge clk); #1 cfg_done = 1'b0;
    quiet = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (cfg_clk || busy || src_ready || cfg_valid) quiet++;
    end
    chk(quiet == 0, "R9 gated idle", quiet, 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(!busy && !cfg_clk && !cfg_valid && !src_ready && !err, "R1 reset state",
        {busy, cfg_clk, cfg_valid, src_ready, err}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Stream with source gaps, target always ready.
    #1 tgt_ready = 1'b1; gap_en = 1'b1; tlim = '0;
    src_total = 24;
    pulse_start();
    wait_rx(24);
    chk(rx_idx == 24, "R3 count gaps", rx_idx, 24);
    chk(tx_idx == 24, "R3 taken gaps", tx_idx, 24);
    do_tail(3);

    // Target not ready: nothing moves, clock still runs.
    tgt_ready = 1'b0; gap_en = 1'b0;
    base = rx_idx;
    src_total += 10;
    pulse_start();
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(rx_idx == base, "R5 no words", rx_idx, base);
    chk(tx_idx == base, "R5 none taken", tx_idx, base);
    chk(busy, "R5 still busy", busy, 1);
    @(posedge clk); #1 tgt_ready = 1'b1;
    wait_rx(src_total);
    chk(rx_idx == src_total, "R3 after ready", rx_idx, src_total);
    do_tail(1);

    // Ready toggling with long low stretches.
    src_total += 40;
    viol = 0;
    pulse_start();
    for (int k = 0; k < 3000 && rx_idx < src_total; k++) begin
      @(posedge clk); #1 tgt_ready = ((k % 13) < 6);
    end
    tgt_ready = 1'b1;
    chk(rx_idx == src_total, "R3 toggled ready", rx_idx, src_total);
    chk(viol == 0, "R4 valid after ready low", viol, 0);
    do_tail(2);

    // Timeout sweep with empty source; start while busy; restart clears.
    for (int L = 1; L <= 4; L++) begin
      tlim = CW'(L);
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (2 * L - 1) @(posedge clk);
      @(negedge clk);
      chk(err == 1'b0, "R7 err not yet", err, 0);
      @(posedge clk);
      @(negedge clk);
      chk(err == 1'b1, "R7 err on time", err, 1);
      base = rx_idx;
      pulse_start();
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(err == 1'b1, "R10 start ignored err", err, 1);
      chk(rx_idx == base, "R10 start ignored stream", rx_idx, base);
      do_tail(L - 1);
      chk(err == 1'b1, "R7 err sticky", err, 1);
    end

    tlim = '0;
    pulse_start();
    @(negedge clk);
    chk(err == 1'b0, "R7 cleared by start", err, 0);
    base = rx_idx;
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(err == 1'b0, "R6 timeout disabled", err, 0);
    chk(rx_idx == base, "R6 empty source no valid", rx_idx, base);
    chk(busy, "R6 still running", busy, 1);
    do_tail(0);

    chk(r2_bad == 0, "R2 clock continuous", r2_bad, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule